// File: doc/BRIEF.md
# Credit-Based Two-Lane Link Sender

This block drives one physical link between two routers. Several virtual channels (two by default) each present flits through their own valid/ready input. All of them share a single outgoing flit bus. Each outgoing flit is tagged with the index of the channel it belongs to. The receiver owns a fixed-depth buffer lane per channel. The sender mirrors the free space in each lane with a credit counter: it spends one credit for every flit it puts on the wire, and it gains one back whenever the receiver reports a freed slot through the credit-return input.

The counters are kept per channel. A channel whose receiver lane is full stalls on its own, and the other channel keeps using the wire. When more than one channel has both a flit and a credit, a round-robin arbiter picks the winner for that cycle.

A flit leaves in the same cycle in which it is accepted. The input handshake and the output flit are combinational, and the credit counters update at the following clock edge. A credit return that would push a counter past the lane depth is dropped, and it raises a one-cycle error flag one cycle later.

Top module: `vc_link_tx`

## Requirements
- R1: After reset, every channel holds LANE_DEPTH credits (4 by default), `out_valid` and `crd_err` are 0, and a lone channel can send exactly 4 flits before it stalls.
- R2: At most one flit leaves per cycle. `out_valid` is 1 only when a channel has `in_valid` set and holds a credit. `out_flit` equals that channel's input flit, `out_vc` carries that channel's index (0 for channel 0, 1 for channel 1), and only that channel sees `in_ready` set.
- R3: Each accepted flit consumes exactly one credit. A channel with zero credits gets no `in_ready` and sends nothing.
- R4: A channel stalled for lack of credits does not stop another channel that holds credits from sending in the same cycle.
- R5: A cycle with `crd_valid` set returns one credit to the channel named by `crd_vc` (0 or 1), and that channel can send one more flit.
- R6: A credit return and a flit send on the same channel in the same cycle leave that channel's credit count unchanged.
- R7: When two or more channels are eligible in consecutive cycles, the grant rotates. Channel 0 wins the first contest after reset, and after that the channel granted most recently has the lowest priority.
- R8: A credit return to a channel that already holds LANE_DEPTH credits, on a cycle with no send on that channel, is dropped. `crd_err` is then 1 for exactly the next cycle, and the counter stays at LANE_DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | NUM_VC | Per-channel flit present |
| in_flit | input | NUM_VC*FLIT_W | Per-channel flit data; channel v at bits [v*FLIT_W +: FLIT_W] |
| in_ready | output | NUM_VC | Per-channel flit accepted this cycle |
| out_valid | output | 1 | Flit on the wire this cycle |
| out_vc | output | VCW | Channel index of the outgoing flit |
| out_flit | output | FLIT_W | Outgoing flit data |
| crd_valid | input | 1 | One credit returned this cycle |
| crd_vc | input | VCW | Channel index of the returned credit |
| crd_err | output | 1 | Pulse: the previous cycle's credit return overflowed |

## Verification
The bench drains channel 0 to zero credits and checks that the fifth flit stalls. A counter that was off by one or reset to the wrong depth would let it pass, or would block it one flit too early. With channel 0 stalled, the bench offers channel 1 a flit to catch a shared stall, which would freeze both lanes. It returns a credit to a full counter to expose a missing saturation, which would wrap the count or grant a phantom fifth send, and a missing error pulse. It also sends and returns on one channel in the same cycle to expose a counter that favours one of the two updates. Sustained two-channel contention and a long pseudo-random phase then check that the grant rotates instead of starving a lane.

// File: rtl/vclt_pkg.sv
package vclt_pkg;

   // Width of a counter able to hold the values 0..depth inclusive.
   function automatic int unsigned cnt_width(input int unsigned depth);
      return (depth < 1) ? 1 : $clog2(depth + 1);
   endfunction

   // Width of an index over n items, never below one bit.
   function automatic int unsigned idx_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

   // Round-robin arbiter state after reset: the last channel counts as the
   // most recent winner, so channel 0 is favoured first.
   typedef enum logic [0:0] {
      ARB_IDLE = 1'b0,
      ARB_SEND = 1'b1
   } arb_state_e;

endpackage

// File: rtl/vclt_credit_ctr.sv
module vclt_credit_ctr
   import vclt_pkg::*;
#(
   parameter int unsigned DEPTH = 4,
   localparam int unsigned CW = cnt_width(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          take_i,
   input  logic          give_i,
   output logic [CW-1:0] count_o,
   output logic          has_credit_o,
   output logic          ovf_o
);

   localparam logic [CW-1:0] FULL = CW'(DEPTH);

   logic [CW-1:0] count_q;

   if (DEPTH < 1) begin : g_bad_depth
      $error("vclt_credit_ctr: DEPTH must be at least 1");
   end

   assign ovf_o        = give_i && !take_i && (count_q == FULL);
   assign has_credit_o = (count_q != '0);
   assign count_o      = count_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q <= FULL;
      end else if (take_i && !give_i) begin
         count_q <= count_q - 1'b1;
      end else if (give_i && !take_i && (count_q != FULL)) begin
         count_q <= count_q + 1'b1;
      end
   end

   // R8
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= FULL);

   // R3
   no_spend_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_i |-> (count_q != '0));

   // R5
   return_adds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (give_i && !take_i && count_q != FULL) |=> (count_q == $past(count_q) + 1'b1));

   // R6
   both_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (give_i && take_i) |=> $stable(count_q));

endmodule

// File: rtl/vclt_rr_arb.sv
module vclt_rr_arb
   import vclt_pkg::*;
#(
   parameter int unsigned N = 2,
   localparam int unsigned IW = idx_width(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req_i,
   output logic [N-1:0]  gnt_o,
   output logic [IW-1:0] gnt_idx_o,
   output logic          any_o
);

   logic [IW-1:0] last_q;
   arb_state_e    state;

   if (N < 2) begin : g_bad_n
      $error("vclt_rr_arb: N must be at least 2");
   end

   always_comb begin
      gnt_o     = '0;
      gnt_idx_o = '0;
      any_o     = 1'b0;
      for (int off = 1; off <= int'(N); off++) begin
         int idx;
         idx = (int'(last_q) + off) % int'(N);
         if (!any_o && req_i[idx]) begin
            any_o      = 1'b1;
            gnt_o[idx] = 1'b1;
            gnt_idx_o  = IW'(idx);
         end
      end
   end

   assign state = any_o ? ARB_SEND : ARB_IDLE;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_q <= IW'(N - 1);
      end else if (state == ARB_SEND) begin
         last_q <= gnt_idx_o;
      end
   end

   // R2
   grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt_o));

   // R2
   grant_in_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_o & ~req_i) == '0);

   // R7
   rr_alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (&req_i) ##1 (&req_i) |-> (gnt_o != $past(gnt_o)));

endmodule

// File: rtl/vc_link_tx.sv
module vc_link_tx
   import vclt_pkg::*;
#(
   parameter int unsigned NUM_VC     = 2,
   parameter int unsigned FLIT_W     = 32,
   parameter int unsigned LANE_DEPTH = 4,
   localparam int unsigned VCW = idx_width(NUM_VC)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_VC-1:0]        in_valid,
   input  logic [NUM_VC*FLIT_W-1:0] in_flit,
   output logic [NUM_VC-1:0]        in_ready,
   output logic                     out_valid,
   output logic [VCW-1:0]           out_vc,
   output logic [FLIT_W-1:0]        out_flit,
   input  logic                     crd_valid,
   input  logic [VCW-1:0]           crd_vc,
   output logic                     crd_err
);

   localparam int unsigned CW = cnt_width(LANE_DEPTH);

   logic [NUM_VC-1:0] has_credit;
   logic [NUM_VC-1:0] give;
   logic [NUM_VC-1:0] ovf;
   logic [NUM_VC-1:0] req;
   logic [NUM_VC-1:0] gnt;
   logic [VCW-1:0]    gnt_idx;
   logic              gnt_any;
   logic              crd_err_q;

   if (NUM_VC < 2) begin : g_bad_vc
      $error("vc_link_tx: NUM_VC must be at least 2");
   end
   if (FLIT_W < 1) begin : g_bad_w
      $error("vc_link_tx: FLIT_W must be at least 1");
   end
   if (LANE_DEPTH < 1) begin : g_bad_depth
      $error("vc_link_tx: LANE_DEPTH must be at least 1");
   end

   for (genvar v = 0; v < int'(NUM_VC); v++) begin : g_lane
      logic [CW-1:0] count;

      assign give[v] = crd_valid && (crd_vc == VCW'(v));
      assign req[v]  = in_valid[v] && has_credit[v];

      vclt_credit_ctr #(
         .DEPTH (LANE_DEPTH)
      ) u_ctr (
         .clk          (clk),
         .rst_n        (rst_n),
         .take_i       (gnt[v]),
         .give_i       (give[v]),
         .count_o      (count),
         .has_credit_o (has_credit[v]),
         .ovf_o        (ovf[v])
      );
   end

   vclt_rr_arb #(
      .N (NUM_VC)
   ) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_i     (req),
      .gnt_o     (gnt),
      .gnt_idx_o (gnt_idx),
      .any_o     (gnt_any)
   );

   assign in_ready  = gnt;
   assign out_valid = gnt_any;
   assign out_vc    = gnt_idx;
   assign out_flit  = in_flit[gnt_idx*FLIT_W +: FLIT_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         crd_err_q <= 1'b0;
      end else begin
         crd_err_q <= |ovf;
      end
   end

   assign crd_err = crd_err_q;

   // R2
   send_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (in_valid[out_vc] && in_ready[out_vc]));

   // R4
   other_lane_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req != '0) |-> out_valid);

   // R8
   err_follows_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|ovf) |=> crd_err);

endmodule

// File: tb/vc_link_tx_test.sv
module vc_link_tx_test;

   localparam int FW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    in_valid = '0;
   logic [2*FW-1:0] in_flit = '0;
   logic [1:0]    in_ready;
   logic          out_valid;
   logic [0:0]    out_vc;
   logic [FW-1:0] out_flit;
   logic          crd_valid = 1'b0;
   logic [0:0]    crd_vc = '0;
   logic          crd_err;

   int n_cmp = 0;
   int n_bad = 0;

   // Scoreboard entry: flit data with the channel tag, plus the requirement.
   logic [FW:0] exp_q[$];
   string       tag_q[$];
   event        sample_ev;

   // Reference state derived from the requirements.
   int m_cred[2];
   int m_last;
   bit m_err_next;

   always #4 clk = ~clk;   // 125 MHz

   vc_link_tx #(.NUM_VC(2), .FLIT_W(FW), .LANE_DEPTH(4)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_flit(in_flit),
      .in_ready(in_ready), .out_valid(out_valid), .out_vc(out_vc),
      .out_flit(out_flit), .crd_valid(crd_valid), .crd_vc(crd_vc),
      .crd_err(crd_err)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // Monitor: pops the expected flit for every cycle the driver marks.
   initial begin
      forever begin
         @(sample_ev);
         if (out_valid) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R2", "unexpected flit", int'(out_flit), 0);
            end else begin
               logic [FW:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check(out_flit == e[FW-1:0], t, "out_flit", int'(out_flit), int'(e[FW-1:0]));
               check(out_vc == e[FW], t, "out_vc", int'(out_vc), int'(e[FW]));
            end
         end else if (exp_q.size() != 0) begin
            string t;
            void'(exp_q.pop_front());
            t = tag_q.pop_front();
            check(1'b0, t, "missing flit", 0, 1);
         end
      end
   end

   task automatic step(input bit v0, input logic [FW-1:0] d0,
                       input bit v1, input logic [FW-1:0] d1,
                       input bit cr, input bit cv, input string tag);
      int g;
      bit el0, el1, ret0, ret1, snd0, snd1;
      @(negedge clk);
      in_valid  = {v1, v0};
      in_flit   = {d1, d0};
      crd_valid = cr;
      crd_vc    = cv;
      #2;
      el0 = v0 && m_cred[0] > 0;
      el1 = v1 && m_cred[1] > 0;
      g = -1;
      if (el0 && el1) g = (m_last == 0) ? 1 : 0;
      else if (el0)   g = 0;
      else if (el1)   g = 1;
      if (g >= 0) begin
         exp_q.push_back({g[0], (g == 0) ? d0 : d1});
         tag_q.push_back(tag);
         m_last = g;
      end
      check(in_ready == {g == 1, g == 0}, tag, "in_ready", int'(in_ready),
            int'({g == 1, g == 0}));
      check(crd_err == m_err_next, tag, "crd_err", int'(crd_err), int'(m_err_next));
      ->sample_ev;
      #1;
      ret0 = cr && cv == 1'b0;
      ret1 = cr && cv == 1'b1;
      snd0 = (g == 0);
      snd1 = (g == 1);
      m_err_next = (ret0 && !snd0 && m_cred[0] == 4) || (ret1 && !snd1 && m_cred[1] == 4);
      if (snd0 && !ret0) m_cred[0]--;
      else if (ret0 && !snd0 && m_cred[0] < 4) m_cred[0]++;
      if (snd1 && !ret1) m_cred[1]--;
      else if (ret1 && !snd1 && m_cred[1] < 4) m_cred[1]++;
   endtask

   task automatic run_all();
      logic [15:0] lfsr;
      m_cred[0] = 4; m_cred[1] = 4; m_last = 1; m_err_next = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: idle after reset
      step(0, 0, 0, 0, 0, 0, "R1");
      // R1 / R3: four sends on channel 0, then a stall
      for (int i = 0; i < 4; i++) step(1, 32'hA000_0000 + i, 0, 0, 0, 0, "R1");
      step(1, 32'hA000_0004, 0, 0, 0, 0, "R3");
      step(1, 32'hA000_0004, 0, 0, 0, 0, "R3");
      // R4: channel 1 moves while channel 0 is stalled
      step(1, 32'hA000_0004, 1, 32'hB000_0000, 0, 0, "R4");
      step(1, 32'hA000_0004, 1, 32'hB000_0001, 0, 0, "R4");
      // R5: one credit back on channel 0, one more send, then a stall
      step(0, 0, 0, 0, 1, 0, "R5");
      step(1, 32'hA000_0005, 0, 0, 0, 0, "R5");
      step(1, 32'hA000_0006, 0, 0, 0, 0, "R5");
      // R6: channel 0 at 1 credit, then send and return together
      step(0, 0, 0, 0, 1, 0, "R6");
      for (int i = 0; i < 3; i++) step(1, 32'hC000_0000 + i, 0, 0, 1, 0, "R6");
      step(1, 32'hC000_0003, 0, 0, 0, 0, "R6");
      step(1, 32'hC000_0004, 0, 0, 0, 0, "R6");
      // R8: fill channel 1, then overflow it
      step(0, 0, 0, 0, 1, 1, "R8");
      step(0, 0, 0, 0, 1, 1, "R8");
      step(0, 0, 0, 0, 1, 1, "R8");
      step(0, 0, 0, 0, 0, 0, "R8");
      step(0, 0, 0, 0, 0, 0, "R8");
      for (int i = 0; i < 5; i++) step(0, 0, 1, 32'hD000_0000 + i, 0, 0, "R8");
      // Refill both lanes
      for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 1, 0, "R5");
      for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 1, 1, "R5");
      // R7: sustained contention with the winner's credit returned each cycle
      for (int i = 0; i < 8; i++)
         step(1, 32'hE000_0000 + i, 1, 32'hF000_0000 + i, 1, i[0], "R7");
      // R2: pseudo-random traffic and returns
      lfsr = 16'hACE1;
      for (int i = 0; i < 400; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         step(lfsr[0], {16'h1234, lfsr}, lfsr[1], {16'h5678, lfsr},
              lfsr[2] | lfsr[3], lfsr[4], "R2");
      end
      step(0, 0, 0, 0, 0, 0, "R2");
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (200000) @(posedge clk);
            check(1'b0, "R1", "watchdog expired", 0, 1);
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule